// File: doc/BRIEF.md
# Redistributor Identification Register Frame

This block answers register accesses aimed at one CPU's redistributor window in a multi-processor interrupt controller. The window is 128 KiB wide and is made of two 64 KiB frames. The control frame sits at the window base. The frame for software-generated and private-peripheral interrupts starts 64 KiB higher. Within these frames the block serves the identification registers and a 64-bit type register. The type register is assembled on every read from three inputs: the CPU's affinity, its index and the CPU count.

Almost every location is read-only, and no write changes anything. The block therefore holds no programmable state. Its only register is the read-data stage, which gives the bus a fixed latency of one cycle. Accesses may be 1, 2, 4 or 8 bytes wide at any naturally aligned offset. A narrow access to a 64-bit slot returns the lanes that the low address bits select.

Top module: `rdist_id_frame`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rdData` is zero.
- R2: A read presented before a rising edge (`busReq`=1, `busWrEn`=0) shows its value on `rdData` right after that edge and holds it for one cycle only. After any edge without a read, `rdData` is zero.
- R3: A 64-bit read at byte offset 0x08 returns the type word. The affinity sits in bits 55:32 and the zero-extended CPU index in bits 23:8. Every other bit is zero except the last-CPU flag.
- R4: The last-CPU flag is bit 4 of the type word. It is 1 exactly when `cpuIdx` equals `cpuCount` minus one.
- R5: The identification word at byte offset 0x04 reads as `PRODUCT_CODE` shifted left by 24, ORed with `IMPL_CODE` in bits 11:0.
- R6: The peripheral-ID2 location at offset 0xFFE8 reads 0x3B. The other locations in the ID area read zero.
- R7: The control register at offset 0x00 reads zero.
- R8: The private-interrupt group register at offset 0x10080 (second frame, offset 0x80) reads 0xFFFFFFFF.
- R9: `busSize` selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A read returns the 64-bit slot at `busAddr[16:3]`, shifted right by 8 times `busAddr[2:0]` and masked to that width.
- R10: A read whose address is not a multiple of its width returns zero.
- R11: A read of any offset not listed above returns zero and raises no error.
- R12: A write (`busWrEn`=1) returns zero on the next cycle. Later reads of every register give the same values as before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReq | input | 1 | Access request, valid for one cycle |
| busWrEn | input | 1 | 1 = write, 0 = read |
| busAddr | input | 17 | Byte offset inside the 128 KiB window |
| busSize | input | 2 | Access width code (0:1 B, 1:2 B, 2:4 B, 3:8 B) |
| busWrData | input | 64 | Write data (always ignored) |
| cpuIdx | input | IDX_W | This CPU's index |
| cpuCount | input | IDX_W+1 | Number of CPUs in the system |
| cpuAff | input | 24 | This CPU's affinity value |
| rdData | output | 64 | Read data, one cycle after the request |

## Verification
Every result comes from a single register. The value for a request driven before a rising edge is therefore due in the half-cycle that follows that edge. The bench drives each request at a falling edge and compares `rdData` at the next falling edge. It then samples one more falling edge with no request, to confirm that the value has returned to zero. The CPU inputs change only at falling edges with no request in flight, so every expected type word is computed from the values that were present at the capturing edge.

// File: rtl/rdist_pkg.sv
package rdist_pkg;
  typedef enum logic [2:0] {
    SLOT_ZERO,
    SLOT_IDENT,
    SLOT_TYPE,
    SLOT_PIDR,
    SLOT_GROUP
  } slotSel_t;

  typedef struct packed {
    logic     rdHit;
    slotSel_t slot;
    logic [2:0] lane;
    logic [1:0] size;
  } rdStrobe_t;

  localparam logic [7:0] PIDR2_VALUE = 8'h3B;
endpackage

// File: rtl/rdist_ctrl.sv
module rdist_ctrl
  import rdist_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              busReq,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output rdStrobe_t         strobe
);
  localparam int SLOT_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] OFS_IDENT = ADDR_W'('h00000);
  localparam logic [ADDR_W-1:0] OFS_TYPE  = ADDR_W'('h00008);
  localparam logic [ADDR_W-1:0] OFS_PIDR  = ADDR_W'('h0FFE8);
  localparam logic [ADDR_W-1:0] OFS_GROUP = ADDR_W'('h10080);

  logic [SLOT_W-1:0] slotIdx;
  logic aligned;

  assign slotIdx = busAddr[ADDR_W-1:3];

  always_comb begin
    unique case (busSize)
      2'd0: aligned = 1'b1;
      2'd1: aligned = ~busAddr[0];
      2'd2: aligned = (busAddr[1:0] == 2'b00);
      default: aligned = (busAddr[2:0] == 3'b000);
    endcase
  end

  always_comb begin
    strobe.rdHit = busReq & ~busWrEn & aligned;
    strobe.lane  = busAddr[2:0];
    strobe.size  = busSize;
    if (slotIdx == OFS_IDENT[ADDR_W-1:3])      strobe.slot = SLOT_IDENT;
    else if (slotIdx == OFS_TYPE[ADDR_W-1:3])  strobe.slot = SLOT_TYPE;
    else if (slotIdx == OFS_PIDR[ADDR_W-1:3])  strobe.slot = SLOT_PIDR;
    else if (slotIdx == OFS_GROUP[ADDR_W-1:3]) strobe.slot = SLOT_GROUP;
    else                                       strobe.slot = SLOT_ZERO;
  end
endmodule

// File: rtl/rdist_dp.sv
module rdist_dp
  import rdist_pkg::*;
#(
  parameter int         IDX_W        = 8,
  parameter int         AFF_W        = 24,
  parameter logic [7:0] PRODUCT_CODE = 8'hA7,
  parameter logic [11:0] IMPL_CODE   = 12'h5D1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rdStrobe_t        strobe,
  input  logic [IDX_W-1:0] cpuIdx,
  input  logic [IDX_W:0]   cpuCount,
  input  logic [AFF_W-1:0] cpuAff,
  output logic [63:0]      rdData
);
  localparam int NUM_SIZES = 4;

  logic [15:0] idxField;
  logic [23:0] affField;
  logic        lastCpu;
  logic [31:0] identWord;
  logic [63:0] typeWord;
  logic [63:0] slotWord;
  logic [63:0] shifted;
  logic [63:0] sizeMask [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_mask
    if (s == NUM_SIZES - 1) begin : g_full
      assign sizeMask[s] = '1;
    end else begin : g_part
      assign sizeMask[s] = (64'd1 << (8 << s)) - 64'd1;
    end
  end

  always_comb begin
    idxField = '0;
    idxField[IDX_W-1:0] = cpuIdx;
    affField = '0;
    affField[AFF_W-1:0] = cpuAff;
  end

  assign lastCpu   = ({1'b0, cpuIdx} == (cpuCount - 1'b1));
  assign identWord = {PRODUCT_CODE, 12'h000, IMPL_CODE};
  assign typeWord  = {8'h00, affField, 8'h00, idxField, 3'b000, lastCpu, 4'h0};

  always_comb begin
    unique case (strobe.slot)
      SLOT_IDENT: slotWord = {identWord, 32'h0};
      SLOT_TYPE:  slotWord = typeWord;
      SLOT_PIDR:  slotWord = {56'h0, PIDR2_VALUE};
      SLOT_GROUP: slotWord = {32'h0, 32'hFFFF_FFFF};
      default:    slotWord = '0;
    endcase
  end

  assign shifted = slotWord >> {strobe.lane, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdHit) rdData <= shifted & sizeMask[strobe.size];
    else rdData <= '0;
  end
endmodule

// File: rtl/rdist_id_frame.sv
module rdist_id_frame
  import rdist_pkg::*;
#(
  parameter int          IDX_W        = 8,
  parameter int          AFF_W        = 24,
  parameter logic [7:0]  PRODUCT_CODE = 8'hA7,
  parameter logic [11:0] IMPL_CODE    = 12'h5D1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReq,
  input  logic             busWrEn,
  input  logic [16:0]      busAddr,
  input  logic [1:0]       busSize,
  input  logic [63:0]      busWrData,
  input  logic [IDX_W-1:0] cpuIdx,
  input  logic [IDX_W:0]   cpuCount,
  input  logic [AFF_W-1:0] cpuAff,
  output logic [63:0]      rdData
);
  rdStrobe_t strobe;

  rdist_ctrl #(.ADDR_W(17)) u_ctrl (
    .busReq (busReq),
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .busSize(busSize),
    .strobe (strobe)
  );

  rdist_dp #(
    .IDX_W(IDX_W), .AFF_W(AFF_W),
    .PRODUCT_CODE(PRODUCT_CODE), .IMPL_CODE(IMPL_CODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cpuIdx  (cpuIdx),
    .cpuCount(cpuCount),
    .cpuAff  (cpuAff),
    .rdData  (rdData)
  );
endmodule

// File: rtl/rdist_id_frame_chk.sv
module rdist_id_frame_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busReq,
  input logic             busWrEn,
  input logic [16:0]      busAddr,
  input logic [1:0]       busSize,
  input logic [63:0]      busWrData,
  input logic [IDX_W-1:0] cpuIdx,
  input logic [IDX_W:0]   cpuCount,
  input logic [63:0]      rdData
);
  logic rdReq;
  assign rdReq = busReq & ~busWrEn;

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |=> rdData == 64'h0);

  a_r12_write_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrEn && busWrData != 64'h0) |=> rdData == 64'h0);

  a_r10_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && busSize == 2'd3 && busAddr[2:0] != 3'b000) |=> rdData == 64'h0);

  a_r9_byte_width: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && busSize == 2'd0) |=> rdData[63:8] == 56'h0);

  a_r4_last_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && busAddr == 17'h00008 && busSize == 2'd3)
      |=> rdData[4] == ({1'b0, $past(cpuIdx)} == ($past(cpuCount) - 1'b1)));

  a_r8_group_ones: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && busAddr == 17'h10080 && busSize == 2'd2) |=> rdData == 64'hFFFF_FFFF);
endmodule

bind rdist_id_frame rdist_id_frame_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWrEn(busWrEn),
  .busAddr(busAddr), .busSize(busSize), .busWrData(busWrData),
  .cpuIdx(cpuIdx), .cpuCount(cpuCount), .rdData(rdData)
);

// File: tb/rdist_id_frame_tb.sv
`timescale 1ns/1ps
module rdist_id_frame_tb;
  localparam int          IDX_W = 8;
  localparam logic [7:0]  PROD  = 8'hA7;
  localparam logic [11:0] IMPL  = 12'h5D1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, busWrEn = 1'b0;
  logic [16:0] busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [63:0] busWrData = '0;
  logic [IDX_W-1:0] cpuIdx = 8'd3;
  logic [IDX_W:0]   cpuCount = 9'd4;
  logic [23:0]      cpuAff = 24'h12_34_56;
  logic [63:0] rdData;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rdist_id_frame #(.IDX_W(IDX_W), .AFF_W(24), .PRODUCT_CODE(PROD), .IMPL_CODE(IMPL)) u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrEn(busWrEn), .busAddr(busAddr),
    .busSize(busSize), .busWrData(busWrData), .cpuIdx(cpuIdx), .cpuCount(cpuCount),
    .cpuAff(cpuAff), .rdData(rdData)
  );

  function automatic logic [63:0] slotOf(input logic [16:0] a);
    logic [16:0] base;
    logic [63:0] w;
    base = {a[16:3], 3'b000};
    w = '0;
    if (base == 17'h00000) w[63:32] = {PROD, 12'h000, IMPL};
    else if (base == 17'h00008) begin
      w[55:32] = cpuAff;
      w[23:8]  = {8'h00, cpuIdx};
      w[4]     = ({1'b0, cpuIdx} == cpuCount - 1);
    end
    else if (base == 17'h0FFE8) w[7:0] = 8'h3B;
    else if (base == 17'h10080) w[31:0] = 32'hFFFF_FFFF;
    return w;
  endfunction

  function automatic logic [63:0] expRead(input logic [16:0] a, input logic [1:0] s);
    int nBytes;
    logic [63:0] v;
    nBytes = 1 << s;
    if ((a % nBytes) != 0) return '0;
    v = slotOf(a) >> (8 * a[2:0]);
    if (nBytes < 8) v = v & ((64'd1 << (8 * nBytes)) - 1);
    return v;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [16:0] a, input logic [1:0] s, input logic wr,
                        input logic [63:0] wd, input logic [63:0] exp, input string req);
    busReq = 1'b1; busWrEn = wr; busAddr = a; busSize = s; busWrData = wd;
    @(negedge clk);
    busReq = 1'b0; busWrEn = 1'b0; busWrData = '0;
    check(rdData, exp, req);
  endtask

  task automatic rd(input logic [16:0] a, input logic [1:0] s, input string req);
    access(a, s, 1'b0, '0, expRead(a, s), req);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    check(rdData, 64'h0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData, 64'h0, "R1 after reset");

    // R3/R4: type word, this CPU is last (idx 3 of 4)
    access(17'h00008, 2'd3, 1'b0, '0, 64'h0012_3456_0000_0310, "R3 type word last");
    @(negedge clk);
    check(rdData, 64'h0, "R2 value held one cycle only");
    cpuCount = 9'd8;
    @(negedge clk);
    access(17'h00008, 2'd3, 1'b0, '0, 64'h0012_3456_0000_0300, "R4 not last");
    cpuIdx = 8'd0; cpuCount = 9'd1;
    @(negedge clk);
    access(17'h00008, 2'd3, 1'b0, '0, 64'h0012_3456_0000_0010, "R4 single cpu last");
    cpuIdx = 8'd3; cpuCount = 9'd4;
    @(negedge clk);
    // R5 identification, R7 control
    access(17'h00004, 2'd2, 1'b0, '0, {32'h0, PROD, 12'h000, IMPL}, "R5 ident word");
    access(17'h00000, 2'd2, 1'b0, '0, 64'h0, "R7 control zero");
    access(17'h00000, 2'd3, 1'b0, '0, {PROD, 12'h000, IMPL, 32'h0}, "R9 64b slot 0");
    // R6 peripheral ID
    access(17'h0FFE8, 2'd2, 1'b0, '0, 64'h3B, "R6 pidr2");
    access(17'h0FFE4, 2'd2, 1'b0, '0, 64'h0, "R6 other id zero");
    // R8 group
    access(17'h10080, 2'd2, 1'b0, '0, 64'hFFFF_FFFF, "R8 group ones");
    access(17'h10081, 2'd0, 1'b0, '0, 64'hFF, "R9 group byte");
    // R9 narrow reads of type word
    access(17'h0000C, 2'd2, 1'b0, '0, 64'h0012_3456, "R9 type upper word");
    access(17'h0000E, 2'd0, 1'b0, '0, 64'h12, "R9 type byte 6");
    access(17'h00009, 2'd0, 1'b0, '0, 64'h03, "R9 type byte 1");
    access(17'h0000A, 2'd1, 1'b0, '0, 64'h0000, "R9 type half");
    // R10 misaligned
    access(17'h0000C, 2'd3, 1'b0, '0, 64'h0, "R10 misaligned 64b");
    access(17'h00006, 2'd2, 1'b0, '0, 64'h0, "R10 misaligned 32b");
    // R11 unmapped
    access(17'h00100, 2'd3, 1'b0, '0, 64'h0, "R11 unmapped ctrl frame");
    access(17'h10000, 2'd3, 1'b0, '0, 64'h0, "R11 unmapped second frame");
    // R12 writes ignored
    access(17'h00008, 2'd3, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, "R12 write returns zero");
    access(17'h00000, 2'd2, 1'b1, 64'hFFFF_FFFF, 64'h0, "R12 ctrl write zero");
    access(17'h10080, 2'd2, 1'b1, 64'h0, 64'h0, "R12 group write zero");
    rd(17'h00008, 2'd3, "R12 type unchanged");
    rd(17'h00000, 2'd3, "R12 slot0 unchanged");
    rd(17'h10080, 2'd2, "R12 group unchanged");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [16:0] a;
      logic [1:0] s;
      int pick;
      if (i % 60 == 0) begin
        cpuIdx = 8'($urandom_range(0, 15));
        cpuCount = ($urandom_range(0, 1) == 1) ? {1'b0, cpuIdx} + 9'd1 : 9'($urandom_range(1, 32));
        cpuAff = 24'($urandom);
        @(negedge clk);
      end
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = 17'h00000;
        1: a = 17'h00008;
        2: a = 17'h0FFE8;
        3: a = 17'h10080;
        4: a = 17'h0FFD0;
        default: a = 17'($urandom);
      endcase
      a[2:0] = 3'($urandom);
      s = 2'($urandom);
      if ($urandom_range(0, 7) == 0)
        access(a, s, 1'b1, {$urandom, $urandom}, 64'h0, "R12 random write");
      else
        rd(a, s, "R9 random read");
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check(rdData, 64'h0, "R2 idle zero");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule